// File: doc/BRIEF.md
# Configuration Bitstream Streaming Controller

The block accepts a configuration image from a host bus and shifts it out, one bit per cycle, to target programmable devices. The host first stages the image length in a byte-count register while the engine is off, then turns the engine on and delivers 32-bit words into an internal FIFO through a fixed data port. Words arrive either from ordinary processor writes or from a DMA engine that the block paces with a level request line. Each word is split into four bytes, highest byte first, and each byte is shifted highest bit first on a data line qualified by a per-bit strobe.

Once every byte of the stated length has left the shifter, the engine waits for the targets to report completion. A completion input sets the done flag. If no completion arrives within a bounded number of cycles, a timeout error is set instead. Either outcome, and any write that finds the FIFO full, raises the interrupt. Writing a control word with the enable bit clear stops the engine, empties the FIFO and drops the interrupt. Setting enable and reset together drives a deconfigure line to the targets until the host writes the control word again.

Register reads are combinational on the address. Write data is taken in word order; byte lane ordering on the wider system bus is left to the bus bridge.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: After reset, CONTROL, STATUS, FIFO_USED, TOTAL and CUR read 0, FIFO_SIZE reads DEPTH*4, and irq_o, dma_req_o, tgt_clk_o and tgt_rst_o are low.
- R2: The register offsets are fixed: CONTROL 0x40 (bit 0 enable, bit 1 reset, bit 2 DMA mode), STATUS 0x44, FIFO_SIZE 0x48, FIFO_USED 0x4C (occupancy in bytes), TOTAL 0x50, CUR 0x54. The FIFO write port is at 0x3000 and takes one 32-bit word per write.
- R3: While running, each FIFO word is shifted MSB first on tgt_dat_o, one bit per cycle in which tgt_clk_o is high. Exactly TOTAL*8 bits are produced for a TOTAL that is a multiple of 4.
- R4: CUR increases by one after every eight bits shifted and equals TOTAL at the end of a run.
- R5: Once CUR equals TOTAL and the shifter is idle, a high tgt_done_i sets STATUS bit 18 and raises irq_o.
- R6: If tgt_done_i stays low for TIMEOUT cycles after that point, STATUS bit 2 is set, bit 18 stays 0, and irq_o rises.
- R7: A FIFO write while the FIFO holds DEPTH words is dropped, sets STATUS bit 1 and raises irq_o.
- R8: Writing CONTROL with bit 0 clear lowers irq_o on the next cycle, stops the engine and empties the FIFO. STATUS keeps its flags.
- R9: Writes to TOTAL are ignored while CONTROL bit 0 is set.
- R10: dma_req_o is high only when CONTROL bits 0 and 2 are set, the engine is running, at least DEPTH/2 words are free, and fewer than TOTAL bytes have been accepted since the start. It is never high in processor mode.
- R11: While CONTROL bits 0 and 1 are both set, tgt_rst_o is high, the FIFO is emptied and no bit is shifted.
- R12: Writing CONTROL with bit 0 set and bit 1 clear from the stopped state starts a run and clears STATUS, CUR and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 16 | Bus byte address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Register read data for addr_i |
| irq_o | output | 1 | Completion or error interrupt |
| dma_req_o | output | 1 | DMA burst request, level |
| tgt_clk_o | output | 1 | Per-bit strobe to targets |
| tgt_dat_o | output | 1 | Serial configuration data |
| tgt_rst_o | output | 1 | Deconfigure pulse to targets |
| tgt_done_i | input | 1 | Targets report configuration done |

## Verification
The bench builds the block with DEPTH of 8 words and TIMEOUT of 16 cycles. The small FIFO makes overflow reachable with nine writes, and it gives a DMA burst size of four. A 64-byte DMA run therefore needs four request cycles and exercises the request falling both on FIFO space and on the byte limit. The short timeout lets the no-done path end within a few dozen cycles.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  localparam logic [15:0] OFS_CTRL  = 16'h0040;
  localparam logic [15:0] OFS_STAT  = 16'h0044;
  localparam logic [15:0] OFS_FSIZE = 16'h0048;
  localparam logic [15:0] OFS_FUSED = 16'h004C;
  localparam logic [15:0] OFS_TOTAL = 16'h0050;
  localparam logic [15:0] OFS_CUR   = 16'h0054;
  localparam logic [15:0] OFS_FIFO  = 16'h3000;

  localparam int CTL_EN  = 0;
  localparam int CTL_RST = 1;
  localparam int CTL_DMA = 2;

  localparam int ST_OVF  = 1;
  localparam int ST_TMO  = 2;
  localparam int ST_DONE = 18;

  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_WAIT,
    SEQ_HALT
  } seq_state_e;
endpackage

// File: rtl/cfg_fifo.sv
module cfg_fifo #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer #(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             busy_o,
  output logic             bit_o,
  output logic             byte_done_o
);
  logic [WIDTH-1:0] sreg_q;
  logic [CW-1:0]    cnt_q;

  assign busy_o      = (cnt_q != '0);
  assign bit_o       = sreg_q[WIDTH-1];
  // last bit of a byte when remaining count is 1 mod 8
  assign byte_done_o = busy_o && (cnt_q[2:0] == 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      cnt_q  <= '0;
    end else if (load_i) begin
      sreg_q <= word_i;
      cnt_q  <= CW'(WIDTH);
    end else if (busy_o) begin
      sreg_q <= {sreg_q[WIDTH-2:0], 1'b0};
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_stream_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int TIMEOUT = 1000000,
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             fifo_empty_i,
  input  logic             ser_busy_i,
  input  logic             byte_done_i,
  input  logic             tgt_done_i,
  output logic             pop_o,
  output seq_state_e       state_o,
  output logic [CNT_W-1:0] cur_o,
  output logic             done_set_o,
  output logic             tmo_set_o
);
  logic [CNT_W-1:0] popped_q;
  logic [TW-1:0]    timer_q;

  assign pop_o = (state_o == SEQ_RUN) && !fifo_empty_i && !ser_busy_i &&
                 (popped_q < total_i);
  assign done_set_o = (state_o == SEQ_WAIT) && tgt_done_i;
  assign tmo_set_o  = (state_o == SEQ_WAIT) && !tgt_done_i &&
                      (timer_q == TW'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o  <= SEQ_IDLE;
      cur_o    <= '0;
      popped_q <= '0;
      timer_q  <= '0;
    end else if (stop_i) begin
      state_o  <= SEQ_IDLE;
    end else if (start_i) begin
      state_o  <= SEQ_RUN;
      cur_o    <= '0;
      popped_q <= '0;
      timer_q  <= '0;
    end else begin
      unique case (state_o)
        SEQ_RUN: begin
          if (pop_o)       popped_q <= popped_q + CNT_W'(WORD_BYTES);
          if (byte_done_i) cur_o    <= cur_o + 1'b1;
          if (!ser_busy_i && (cur_o == total_i)) state_o <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (done_set_o || tmo_set_o) state_o <= SEQ_HALT;
          else                         timer_q <= timer_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int TIMEOUT = 1000000,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int BURST = DEPTH / 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        dma_req_o,
  output logic        tgt_clk_o,
  output logic        tgt_dat_o,
  output logic        tgt_rst_o,
  input  logic        tgt_done_i
);
  localparam logic [31:0] FSIZE_B = 32'(DEPTH * WORD_BYTES);

  logic [2:0]  ctrl_q;
  logic [31:0] total_q, fed_q, cur_w, stat_w;
  logic        st_ovf_q, st_tmo_q, st_done_q, irq_q;
  logic        ctrl_wr, fifo_wr, start, stop, push, ovf;
  logic        fifo_full, fifo_empty, pop, ser_busy, byte_done;
  logic        done_set, tmo_set;
  logic [31:0] fifo_word;
  logic [CW-1:0] fifo_cnt;
  seq_state_e  state;

  assign ctrl_wr = wr_en_i && (addr_i == OFS_CTRL);
  assign fifo_wr = wr_en_i && (addr_i == OFS_FIFO);
  // enable clear or reset request both halt the engine
  assign stop    = ctrl_wr && (!wdata_i[CTL_EN] || wdata_i[CTL_RST]);
  assign start   = ctrl_wr && wdata_i[CTL_EN] && !wdata_i[CTL_RST] &&
                   (state == SEQ_IDLE);
  assign push    = fifo_wr && !fifo_full;
  assign ovf     = fifo_wr && fifo_full;

  cfg_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (stop),
    .push_i  (push),
    .data_i  (wdata_i),
    .pop_i   (pop),
    .data_o  (fifo_word),
    .count_o (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  cfg_serializer #(.WIDTH(32)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (stop),
    .load_i      (pop),
    .word_i      (fifo_word),
    .busy_o      (ser_busy),
    .bit_o       (tgt_dat_o),
    .byte_done_o (byte_done)
  );

  cfg_seq #(.CNT_W(32), .TIMEOUT(TIMEOUT)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .stop_i       (stop),
    .total_i      (total_q),
    .fifo_empty_i (fifo_empty),
    .ser_busy_i   (ser_busy),
    .byte_done_i  (byte_done),
    .tgt_done_i   (tgt_done_i),
    .pop_o        (pop),
    .state_o      (state),
    .cur_o        (cur_w),
    .done_set_o   (done_set),
    .tmo_set_o    (tmo_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      total_q   <= '0;
      fed_q     <= '0;
      st_ovf_q  <= 1'b0;
      st_tmo_q  <= 1'b0;
      st_done_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata_i[2:0];
      if (wr_en_i && (addr_i == OFS_TOTAL) && !ctrl_q[CTL_EN]) total_q <= wdata_i;

      if (start)     fed_q <= '0;
      else if (push) fed_q <= fed_q + 32'(WORD_BYTES);

      if (start) begin
        st_ovf_q  <= 1'b0;
        st_tmo_q  <= 1'b0;
        st_done_q <= 1'b0;
      end else begin
        if (ovf)      st_ovf_q  <= 1'b1;
        if (tmo_set)  st_tmo_q  <= 1'b1;
        if (done_set) st_done_q <= 1'b1;
      end

      if (stop || start)                 irq_q <= 1'b0;
      else if (ovf || tmo_set || done_set) irq_q <= 1'b1;
    end
  end

  always_comb begin
    stat_w          = '0;
    stat_w[ST_OVF]  = st_ovf_q;
    stat_w[ST_TMO]  = st_tmo_q;
    stat_w[ST_DONE] = st_done_q;
  end

  always_comb begin
    unique case (addr_i)
      OFS_CTRL:  rdata_o = {29'd0, ctrl_q};
      OFS_STAT:  rdata_o = stat_w;
      OFS_FSIZE: rdata_o = FSIZE_B;
      OFS_FUSED: rdata_o = 32'(fifo_cnt) << 2;
      OFS_TOTAL: rdata_o = total_q;
      OFS_CUR:   rdata_o = cur_w;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o     = irq_q;
  assign tgt_clk_o = ser_busy;
  assign tgt_rst_o = ctrl_q[CTL_EN] && ctrl_q[CTL_RST];
  assign dma_req_o = ctrl_q[CTL_EN] && ctrl_q[CTL_DMA] && (state == SEQ_RUN) &&
                     ((32'(fifo_cnt) + 32'(BURST)) <= 32'(DEPTH)) &&
                     (fed_q < total_q);
endmodule

// File: rtl/cfg_stream_chk.sv
module cfg_stream_chk #(
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [15:0]   addr_i,
  input logic [31:0]   wdata_i,
  input logic          irq_o,
  input logic          dma_req_o,
  input logic          tgt_clk_o,
  input logic          tgt_rst_o,
  input logic [2:0]    ctrl_q,
  input logic [31:0]   total_q,
  input logic          st_done_q,
  input logic          st_tmo_q,
  input logic [CW-1:0] fifo_cnt
);
  // R8
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 16'h0040 && !wdata_i[0]) |=> !irq_o);
  // R10
  dma_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (ctrl_q[2] && ctrl_q[0]));
  // R11
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rst_o |-> !tgt_clk_o);
  // R3
  shift_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_clk_o |-> ctrl_q[0]);
  // R6
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_done_q && st_tmo_q));
  // R7
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fifo_cnt) <= 32'(DEPTH));
  // R9
  total_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 16'h0050 && ctrl_q[0]) |=> $stable(total_q));
endmodule

bind cfg_stream_ctrl cfg_stream_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .dma_req_o (dma_req_o),
  .tgt_clk_o (tgt_clk_o),
  .tgt_rst_o (tgt_rst_o),
  .ctrl_q    (ctrl_q),
  .total_q   (total_q),
  .st_done_q (st_done_q),
  .st_tmo_q  (st_tmo_q),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/tb_cfg_stream_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_stream_ctrl;
  localparam int DEPTH   = 8;
  localparam int TIMEOUT = 16;
  localparam logic [15:0] A_CTRL = 16'h0040, A_STAT = 16'h0044, A_FSIZE = 16'h0048,
                          A_FUSED = 16'h004C, A_TOTAL = 16'h0050, A_CUR = 16'h0054,
                          A_FIFO = 16'h3000;
  localparam logic [31:0] S_OVF = 32'h2, S_TMO = 32'h4, S_DONE = 32'h0004_0000;

  // {first word, second word, word count}
  localparam logic [95:0] VEC [4] = '{
    {32'hA5C3_0F81, 32'h0000_0000, 32'd1},
    {32'h1234_5678, 32'h9ABC_DEF0, 32'd2},
    {32'h8000_0001, 32'h0000_0000, 32'd1},
    {32'h00FF_00FF, 32'hFF00_FF00, 32'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, tgt_done = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, dma_req, tgt_clk, tgt_dat, tgt_rst;

  int checks = 0, errors = 0, cap_n = 0;
  logic [63:0] cap = '0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_stream_ctrl #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .dma_req_o(dma_req), .tgt_clk_o(tgt_clk),
    .tgt_dat_o(tgt_dat), .tgt_rst_o(tgt_rst), .tgt_done_i(tgt_done)
  );

  always @(negedge clk) begin
    if (tgt_clk) begin
      cap   <= {cap[62:0], tgt_dat};
      cap_n <= cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bus_rd(a, d);
    check(d == exp, tag, 64'(d), 64'(exp));
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, w1, nw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 reset state and register map
    rd_chk(A_CTRL, 32'h0, "R1 ctrl");
    rd_chk(A_STAT, 32'h0, "R1 status");
    rd_chk(A_FSIZE, 32'(DEPTH * 4), "R2 fifo size");
    rd_chk(A_FUSED, 32'h0, "R1 fifo used");
    rd_chk(A_TOTAL, 32'h0, "R1 total");
    rd_chk(A_CUR, 32'h0, "R1 cur");
    check({irq, dma_req, tgt_clk, tgt_rst} == 4'b0, "R1 outputs",
          64'({irq, dma_req, tgt_clk, tgt_rst}), 64'h0);

    // R3 R4 R5 table-driven processor-fed runs
    foreach (VEC[k]) begin
      {w0, w1, nw} = VEC[k];
      bus_wr(A_CTRL, 32'h0);
      bus_wr(A_TOTAL, nw * 4);
      cap_n = 0;
      tgt_done = 1'b1;
      bus_wr(A_CTRL, 32'h1);
      bus_wr(A_FIFO, w0);
      if (nw == 2) bus_wr(A_FIFO, w1);
      wait_irq(400);
      check(cap_n == int'(nw * 32), "R3 bit count", 64'(cap_n), 64'(nw * 32));
      if (nw == 2) check(cap == {w0, w1}, "R3 data", cap, {w0, w1});
      else         check(cap[31:0] == w0, "R3 data", 64'(cap[31:0]), 64'(w0));
      rd_chk(A_CUR, nw * 4, "R4 cur bytes");
      rd_chk(A_STAT, S_DONE, "R5 done flag");
      check(irq == 1'b1, "R5 irq", 64'(irq), 64'h1);
    end
    tgt_done = 1'b0;

    // R8 irq cleared, status kept
    bus_wr(A_CTRL, 32'h0);
    check(irq == 1'b0, "R8 irq clear", 64'(irq), 64'h0);
    rd_chk(A_STAT, S_DONE, "R8 status kept");

    // R9 R10 R6: no done, processor mode
    bus_wr(A_TOTAL, 32'd8);
    bus_wr(A_CTRL, 32'h1);
    bus_wr(A_TOTAL, 32'd100);
    rd_chk(A_TOTAL, 32'd8, "R9 total locked");
    check(dma_req == 1'b0, "R10 no req in cpu mode", 64'(dma_req), 64'h0);
    bus_wr(A_FIFO, 32'hDEAD_BEEF);
    bus_wr(A_FIFO, 32'hCAFE_F00D);
    check(irq == 1'b0, "R6 no early irq", 64'(irq), 64'h0);
    wait_irq(400);
    check(irq == 1'b1, "R6 timeout irq", 64'(irq), 64'h1);
    rd_chk(A_STAT, S_TMO, "R6 timeout flag");
    rd_chk(A_CUR, 32'd8, "R4 cur after timeout");

    // R7 overflow while stopped, then R8 flush
    bus_wr(A_CTRL, 32'h0);
    for (int i = 0; i < DEPTH + 1; i++) bus_wr(A_FIFO, 32'(i));
    rd_chk(A_FUSED, 32'(DEPTH * 4), "R7 fifo full bytes");
    rd_chk(A_STAT, S_TMO | S_OVF, "R7 overflow flag");
    check(irq == 1'b1, "R7 irq", 64'(irq), 64'h1);
    bus_wr(A_CTRL, 32'h0);
    rd_chk(A_FUSED, 32'h0, "R8 fifo flushed");
    check(irq == 1'b0, "R8 irq clear after ovf", 64'(irq), 64'h0);

    // R12 start clears status and cur
    bus_wr(A_TOTAL, 32'd4);
    bus_wr(A_CTRL, 32'h1);
    rd_chk(A_STAT, 32'h0, "R12 status cleared");
    rd_chk(A_CUR, 32'h0, "R12 cur cleared");

    // R11 deconfigure pulse
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_FIFO, 32'h5555_AAAA);
    cap_n = 0;
    bus_wr(A_CTRL, 32'h3);
    check(tgt_rst == 1'b1, "R11 rst high", 64'(tgt_rst), 64'h1);
    repeat (40) @(negedge clk);
    check(cap_n == 0, "R11 no shifting", 64'(cap_n), 64'h0);
    rd_chk(A_FUSED, 32'h0, "R11 fifo emptied");
    bus_wr(A_CTRL, 32'h0);
    check(tgt_rst == 1'b0, "R11 rst low", 64'(tgt_rst), 64'h0);

    // R10 DMA-paced run of 16 words
    bus_wr(A_TOTAL, 32'd64);
    tgt_done = 1'b1;
    cap_n = 0;
    bus_wr(A_CTRL, 32'h5);
    check(dma_req == 1'b1, "R10 req at start", 64'(dma_req), 64'h1);
    begin
      int fed = 0;
      for (int t = 0; t < 4000 && fed < 16; t++) begin
        @(negedge clk);
        if (dma_req) begin
          for (int b = 0; b < DEPTH / 2; b++) begin
            bus_wr(A_FIFO, 32'hC0DE_0000 ^ (32'(fed) * 32'h1111_1111));
            fed++;
          end
        end
      end
      check(fed == 16, "R10 words requested", 64'(fed), 64'd16);
    end
    check(dma_req == 1'b0, "R10 req drops at limit", 64'(dma_req), 64'h0);
    wait_irq(2000);
    check(cap_n == 512, "R3 dma bit count", 64'(cap_n), 64'd512);
    w0 = 32'hC0DE_0000 ^ (32'd14 * 32'h1111_1111);
    w1 = 32'hC0DE_0000 ^ (32'd15 * 32'h1111_1111);
    check(cap == {w0, w1}, "R3 dma tail data", cap, {w0, w1});
    rd_chk(A_CUR, 32'd64, "R4 dma cur");
    rd_chk(A_STAT, S_DONE, "R5 dma done");
    bus_wr(A_CTRL, 32'h0);
    tgt_done = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule